// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block runs at the pixel clock and walks through one horizontal line of an interline CCD readout. At the first clock of each line it raises a one-clock line-start strobe. At every clock it labels the pixel position as a dummy bit, optical black, effective, or idle tail. While pixels are still being shifted out it holds a horizontal-transfer enable high. Inside the effective area it reports the index of the current pixel.

A normal line lasts 2669 clocks. A vertical sequencer supplies the number of the line about to start, the readout mode and the 60/50 Hz standard. For a few line numbers in each mode and standard, the line is cut short, so that the frame period comes out exact. The block samples these selects on the last clock of each line, and the new length applies to the line that starts on the next clock.

The behaviour is a five-state machine over a line-position counter:
- `ST_DUMMY`: dummy bits.
- `ST_OB_LEAD`: leading optical black.
- `ST_ACTIVE`: effective pixels.
- `ST_OB_TRAIL`: trailing optical black.
- `ST_IDLE`: the rest of the line.

The transitions are:
- dummy to lead at position 27.
- lead to active at position 43.
- active to trail at position 2355.
- trail to idle at position 2411.
- From every state, a line-end wrap back to `ST_DUMMY` on the last clock of the current line length. This wrap takes priority over the other transitions.

Top module: `ccd_hline_gen`

## Requirements
- R1: While reset is held, the outputs read as line position 0: `hd`=1, `region`=0, `htx_en`=1, `eff_idx`=0.
- R2: `hd` is high for exactly one clock at line position 0. With no short-line match, the line is 2669 clocks long, so `hd` repeats every 2669 clocks.
- R3: `region` is a 2-bit code by line position:
  - 0 for positions 0–27 (dummy).
  - 1 for positions 28–43 (leading optical black).
  - 2 for positions 44–2355 (effective).
  - 1 for positions 2356–2411 (trailing optical black).
  - 3 from position 2412 to the end of the line (idle).
- R4: `htx_en` is 1 when `region` is 0, 1 or 2, and 0 when `region` is 3.
- R5: `eff_idx` behaves as follows within a line:
  - It is 0 from line start through the leading optical black.
  - In the effective region it equals line position minus 44, running 0 to 2311.
  - After the effective region it holds at 2311 until the next `hd`.
- R6: Full-resolution readout (`mode`=0):
  - With `std_50hz`=0, lines 1013 and 2026 last 1672 clocks.
  - With `std_50hz`=1, lines 945 and 1890 last 464 clocks.
- R7: Fast preview readout (`mode`=1):
  - With `std_50hz`=0, lines 225 and 226 last 1372 clocks.
  - With `std_50hz`=1, line 270 lasts 2039 clocks.
- R8: Wide crop readout (`mode`=2):
  - With `std_50hz`=0, line 113 lasts 1372 clocks.
  - With `std_50hz`=1, line 135 lasts 2354 clocks.
- R9: Narrow crop readout (`mode`=3):
  - With `std_50hz`=0, line 57 lasts 686 clocks.
  - With `std_50hz`=1, line 68 lasts 1177 clocks.
- R10: A line number that is not listed for the selected mode and standard gives a 2669-clock line, even when that number is listed for another mode or standard.
- R11: The selects are sampled only on the last clock of a line. The first line after reset is always 2669 clocks, and a change in the selects during a line does not alter that line's length.
- R12: A shortened line ends wherever its length falls, even inside the effective region. On the next clock, `hd`=1, `region`=0 and `eff_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Readout mode: 0 full, 1 preview, 2 wide crop, 3 narrow crop |
| std_50hz | input | 1 | Frame standard: 0 for 60 Hz, 1 for 50 Hz |
| line_num | input | 12 | Number of the line about to start |
| hd | output | 1 | Line-start strobe |
| htx_en | output | 1 | Horizontal transfer enable |
| region | output | 2 | Pixel region code |
| eff_idx | output | 12 | Pixel index within the effective area |

## Verification
The assertions check the following on every clock:
- the position counter steps by one or wraps to zero at the line end, and stays below the latched line length;
- idle is followed only by idle or a new line;
- the strobe never lasts two clocks;
- the effective index is zero at every line start and 2311 throughout the idle tail.

Only the bench scenarios can show the exact region boundaries and the length chosen for each mode, standard and line number. The same holds for the one-line delay between the selects and the length they take effect on.

// File: rtl/ccd_hline_pkg.sv
package ccd_hline_pkg;

    typedef enum logic [2:0] {
        ST_DUMMY    = 3'd0,
        ST_OB_LEAD  = 3'd1,
        ST_ACTIVE   = 3'd2,
        ST_OB_TRAIL = 3'd3,
        ST_IDLE     = 3'd4
    } hstate_t;

    typedef enum logic [1:0] {
        RG_DUMMY = 2'd0,
        RG_OB    = 2'd1,
        RG_EFF   = 2'd2,
        RG_IDLE  = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        MD_FULL    = 2'd0,
        MD_PREVIEW = 2'd1,
        MD_CROP_W  = 2'd2,
        MD_CROP_N  = 2'd3
    } rmode_t;

    // Short-line table: line numbers and their clock counts per mode/standard.
    localparam int unsigned FULL60_LA  = 1013;
    localparam int unsigned FULL60_LB  = 2026;
    localparam int unsigned FULL60_LEN = 1672;
    localparam int unsigned FULL50_LA  = 945;
    localparam int unsigned FULL50_LB  = 1890;
    localparam int unsigned FULL50_LEN = 464;
    localparam int unsigned PRV60_LA   = 225;
    localparam int unsigned PRV60_LB   = 226;
    localparam int unsigned PRV60_LEN  = 1372;
    localparam int unsigned PRV50_LA   = 270;
    localparam int unsigned PRV50_LEN  = 2039;
    localparam int unsigned CRW60_LA   = 113;
    localparam int unsigned CRW60_LEN  = 1372;
    localparam int unsigned CRW50_LA   = 135;
    localparam int unsigned CRW50_LEN  = 2354;
    localparam int unsigned CRN60_LA   = 57;
    localparam int unsigned CRN60_LEN  = 686;
    localparam int unsigned CRN50_LA   = 68;
    localparam int unsigned CRN50_LEN  = 1177;

endpackage

// File: rtl/ccd_hline_len.sv
module ccd_hline_len
    import ccd_hline_pkg::*;
#(
    parameter int POS_W     = 12,
    parameter int LINE_W    = 12,
    parameter int LINE_CLKS = 2669
) (
    input  logic [1:0]        mode,
    input  logic              std_50hz,
    input  logic [LINE_W-1:0] line_num,
    output logic [POS_W-1:0]  next_len
);

    localparam logic [POS_W-1:0] NORM_LEN = POS_W'(LINE_CLKS);

    function automatic logic hit(input logic [LINE_W-1:0] ln,
                                 input int unsigned a, input int unsigned b);
        return (ln == LINE_W'(a)) || (ln == LINE_W'(b));
    endfunction

    logic [POS_W-1:0] short_len;
    logic             match;

    always_comb begin
        match     = 1'b0;
        short_len = NORM_LEN;
        unique case ({mode, std_50hz})
            {MD_FULL, 1'b0}: begin
                match     = hit(line_num, FULL60_LA, FULL60_LB);
                short_len = POS_W'(FULL60_LEN);
            end
            {MD_FULL, 1'b1}: begin
                match     = hit(line_num, FULL50_LA, FULL50_LB);
                short_len = POS_W'(FULL50_LEN);
            end
            {MD_PREVIEW, 1'b0}: begin
                match     = hit(line_num, PRV60_LA, PRV60_LB);
                short_len = POS_W'(PRV60_LEN);
            end
            {MD_PREVIEW, 1'b1}: begin
                match     = hit(line_num, PRV50_LA, PRV50_LA);
                short_len = POS_W'(PRV50_LEN);
            end
            {MD_CROP_W, 1'b0}: begin
                match     = hit(line_num, CRW60_LA, CRW60_LA);
                short_len = POS_W'(CRW60_LEN);
            end
            {MD_CROP_W, 1'b1}: begin
                match     = hit(line_num, CRW50_LA, CRW50_LA);
                short_len = POS_W'(CRW50_LEN);
            end
            {MD_CROP_N, 1'b0}: begin
                match     = hit(line_num, CRN60_LA, CRN60_LA);
                short_len = POS_W'(CRN60_LEN);
            end
            {MD_CROP_N, 1'b1}: begin
                match     = hit(line_num, CRN50_LA, CRN50_LA);
                short_len = POS_W'(CRN50_LEN);
            end
            default: begin
                match     = 1'b0;
                short_len = NORM_LEN;
            end
        endcase
        next_len = match ? short_len : NORM_LEN;
    end

endmodule

// File: rtl/ccd_hline_fsm.sv
module ccd_hline_fsm
    import ccd_hline_pkg::*;
#(
    parameter int POS_W        = 12,
    parameter int LINE_CLKS    = 2669,
    parameter int DUMMY_BITS   = 28,
    parameter int OB_LEAD_PIX  = 16,
    parameter int EFF_PIX      = 2312,
    parameter int OB_TRAIL_PIX = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] next_len,
    output logic             line_end,
    output logic             eff_adv,
    output logic             hd,
    output logic             htx_en,
    output logic [1:0]       region
);

    localparam logic [POS_W-1:0] DUMMY_LAST = POS_W'(DUMMY_BITS - 1);
    localparam logic [POS_W-1:0] LEAD_LAST  = POS_W'(DUMMY_BITS + OB_LEAD_PIX - 1);
    localparam logic [POS_W-1:0] ACT_LAST   = POS_W'(DUMMY_BITS + OB_LEAD_PIX + EFF_PIX - 1);
    localparam logic [POS_W-1:0] TRAIL_LAST =
        POS_W'(DUMMY_BITS + OB_LEAD_PIX + EFF_PIX + OB_TRAIL_PIX - 1);

    hstate_t          state, state_nxt;
    logic [POS_W-1:0] pos, pos_nxt;
    logic [POS_W-1:0] len_cur;

    always_comb line_end = (pos == len_cur - POS_W'(1));

    // Next-state logic: line-end wrap has priority over region boundaries.
    always_comb begin
        state_nxt = state;
        if (line_end) begin
            state_nxt = ST_DUMMY;
        end else begin
            unique case (state)
                ST_DUMMY:    if (pos == DUMMY_LAST) state_nxt = ST_OB_LEAD;
                ST_OB_LEAD:  if (pos == LEAD_LAST)  state_nxt = ST_ACTIVE;
                ST_ACTIVE:   if (pos == ACT_LAST)   state_nxt = ST_OB_TRAIL;
                ST_OB_TRAIL: if (pos == TRAIL_LAST) state_nxt = ST_IDLE;
                ST_IDLE:     state_nxt = ST_IDLE;
                default:     state_nxt = ST_DUMMY;
            endcase
        end
        pos_nxt = line_end ? '0 : pos + POS_W'(1);
        eff_adv = (state == ST_ACTIVE) && (state_nxt == ST_ACTIVE);
    end

    // State register, position counter and latched line length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DUMMY;
            pos     <= '0;
            len_cur <= POS_W'(LINE_CLKS);
        end else begin
            state <= state_nxt;
            pos   <= pos_nxt;
            if (line_end) len_cur <= next_len;
        end
    end

    // Output decode.
    always_comb begin
        hd     = (state == ST_DUMMY) && (pos == '0);
        htx_en = (state != ST_IDLE);
        unique case (state)
            ST_DUMMY:    region = RG_DUMMY;
            ST_OB_LEAD:  region = RG_OB;
            ST_ACTIVE:   region = RG_EFF;
            ST_OB_TRAIL: region = RG_OB;
            ST_IDLE:     region = RG_IDLE;
            default:     region = RG_DUMMY;
        endcase
    end

    // R2: position advances by one inside a line
    a_r2_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> pos == $past(pos) + POS_W'(1));

    // R2: position never reaches the latched length
    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos < len_cur);

    // R12: a line end restarts at position zero in the dummy state
    a_r12_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (pos == '0) && (state == ST_DUMMY));

    // R3: idle only leads to idle or a new line
    a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> (state == ST_IDLE) || (state == ST_DUMMY));

endmodule

// File: rtl/ccd_hline_eff.sv
module ccd_hline_eff #(
    parameter int EFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic             eff_adv,
    output logic [EFF_W-1:0] eff_idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        eff_idx <= '0;
        else if (line_end) eff_idx <= '0;
        else if (eff_adv)  eff_idx <= eff_idx + EFF_W'(1);
    end

endmodule

// File: rtl/ccd_hline_gen.sv
module ccd_hline_gen
    import ccd_hline_pkg::*;
#(
    parameter int LINE_CLKS    = 2669,
    parameter int DUMMY_BITS   = 28,
    parameter int OB_LEAD_PIX  = 16,
    parameter int EFF_PIX      = 2312,
    parameter int OB_TRAIL_PIX = 56,
    parameter int LINE_W       = 12,
    parameter int POS_W        = $clog2(LINE_CLKS + 1),
    parameter int EFF_W        = $clog2(EFF_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              std_50hz,
    input  logic [LINE_W-1:0] line_num,
    output logic              hd,
    output logic              htx_en,
    output logic [1:0]        region,
    output logic [EFF_W-1:0]  eff_idx
);

    logic [POS_W-1:0] next_len;
    logic             line_end;
    logic             eff_adv;

    ccd_hline_len #(
        .POS_W    (POS_W),
        .LINE_W   (LINE_W),
        .LINE_CLKS(LINE_CLKS)
    ) u_len (
        .mode    (mode),
        .std_50hz(std_50hz),
        .line_num(line_num),
        .next_len(next_len)
    );

    ccd_hline_fsm #(
        .POS_W       (POS_W),
        .LINE_CLKS   (LINE_CLKS),
        .DUMMY_BITS  (DUMMY_BITS),
        .OB_LEAD_PIX (OB_LEAD_PIX),
        .EFF_PIX     (EFF_PIX),
        .OB_TRAIL_PIX(OB_TRAIL_PIX)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_len(next_len),
        .line_end(line_end),
        .eff_adv (eff_adv),
        .hd      (hd),
        .htx_en  (htx_en),
        .region  (region)
    );

    ccd_hline_eff #(
        .EFF_W(EFF_W)
    ) u_eff (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_end(line_end),
        .eff_adv (eff_adv),
        .eff_idx (eff_idx)
    );

    // R2: line-start strobe lasts one clock
    a_r2_hd_single: assert property (@(posedge clk) disable iff (!rst_n)
        hd |=> !hd);

    // R5: index restarts at each line start
    a_r5_idx_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        hd |-> eff_idx == '0);

    // R5: index holds the last effective value through the idle tail
    a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        region == RG_IDLE |-> eff_idx == EFF_W'(EFF_PIX - 1));

    // R5: index never passes the effective width
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eff_idx <= EFF_W'(EFF_PIX - 1));

endmodule

// File: tb/tb_ccd_hline_gen.sv
module tb_ccd_hline_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        std_50hz;
    logic [11:0] line_num;
    logic        hd, htx_en;
    logic [1:0]  region;
    logic [11:0] eff_idx;

    always #5 clk = ~clk;

    ccd_hline_gen dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .std_50hz(std_50hz),
        .line_num(line_num), .hd(hd), .htx_en(htx_en), .region(region),
        .eff_idx(eff_idx)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // {mode[2], std[1], line[12], expected length[12]}
    localparam int NVEC = 16;
    localparam logic [26:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 12'd1013, 12'd1672},   // R6
        {2'd0, 1'b0, 12'd2026, 12'd1672},   // R6
        {2'd0, 1'b1, 12'd945,  12'd464},    // R6
        {2'd0, 1'b1, 12'd1890, 12'd464},    // R6
        {2'd1, 1'b0, 12'd225,  12'd1372},   // R7
        {2'd1, 1'b0, 12'd226,  12'd1372},   // R7
        {2'd1, 1'b1, 12'd270,  12'd2039},   // R7
        {2'd2, 1'b0, 12'd113,  12'd1372},   // R8
        {2'd2, 1'b1, 12'd135,  12'd2354},   // R8
        {2'd3, 1'b0, 12'd57,   12'd686},    // R9
        {2'd3, 1'b1, 12'd68,   12'd1177},   // R9
        {2'd0, 1'b0, 12'd945,  12'd2669},   // R10
        {2'd1, 1'b0, 12'd1013, 12'd2669},   // R10
        {2'd3, 1'b1, 12'd57,   12'd2669},   // R10
        {2'd2, 1'b0, 12'd114,  12'd2669},   // R10
        {2'd0, 1'b0, 12'd0,    12'd2669}    // R10
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_region(input int p);
        if (p < 28)   return 0;
        if (p < 44)   return 1;
        if (p < 2356) return 2;
        if (p < 2412) return 1;
        return 3;
    endfunction

    function automatic int exp_eff(input int p);
        if (p < 44)   return 0;
        if (p < 2356) return p - 44;
        return 2311;
    endfunction

    task automatic set_sel(input logic [1:0] m, input logic s, input logic [11:0] l);
        mode = m; std_50hz = s; line_num = l;
    endtask

    // Starts on a negedge where hd is high; returns clocks to the next hd.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!hd && n < 5000);
    endtask

    // Walk a whole line from its hd cycle, checking R3, R4, R5 per position.
    task automatic walk_line(input int len, input string tag);
        for (int p = 0; p < len; p++) begin
            chk(region == 2'(exp_region(p)), {tag, " R3 region"}, region, exp_region(p));
            chk(htx_en == (exp_region(p) != 3), {tag, " R4 htx_en"}, htx_en,
                int'(exp_region(p) != 3));
            chk(eff_idx == 12'(exp_eff(p)), {tag, " R5 eff_idx"}, eff_idx, exp_eff(p));
            @(negedge clk);
        end
        chk(hd == 1'b1, {tag, " R12 hd after line end"}, hd, 1);
        chk(region == 2'd0, {tag, " R12 region after line end"}, region, 0);
        chk(eff_idx == 12'd0, {tag, " R12 eff_idx after line end"}, eff_idx, 0);
    endtask

    initial begin
        #(1_800_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0;
        // R11: selects for a short line held across reset
        set_sel(2'd0, 1'b1, 12'd945);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(hd == 1'b1,       "R1 hd in reset", hd, 1);
        chk(region == 2'd0,   "R1 region in reset", region, 0);
        chk(htx_en == 1'b1,   "R1 htx_en in reset", htx_en, 1);
        chk(eff_idx == 12'd0, "R1 eff_idx in reset", eff_idx, 0);
        rst_n = 1'b1;

        // R11: first line after reset is normal length despite selects
        measure(n);
        chk(n == 2669, "R11 first line length", n, 2669);
        // R6: the next line uses the sampled short selects
        measure(n);
        chk(n == 464, "R6 full 50Hz short line", n, 464);
        // This line is also 464 (selects unchanged at its start); go normal now.
        set_sel(2'd0, 1'b0, 12'd5);
        walk_line(464, "R12 truncated");
        walk_line(2669, "R2 normal");

        // Table walk: selects set at each hd take effect on the following line.
        set_sel(VEC[0][26:25], VEC[0][24], VEC[0][23:12]);
        measure(n);
        chk(n == 2669, "R11 line before table", n, 2669);
        for (int i = 0; i < NVEC; i++) begin
            if (i + 1 < NVEC)
                set_sel(VEC[i+1][26:25], VEC[i+1][24], VEC[i+1][23:12]);
            else
                set_sel(2'd0, 1'b0, 12'd5);
            measure(n);
            chk(n == int'(VEC[i][11:0]),
                $sformatf("R6-9/R10 vector %0d length (R6 R7 R8 R9 R10)", i),
                n, int'(VEC[i][11:0]));
        end

        // R11: change selects mid-line; current line keeps its length
        repeat (100) @(negedge clk);
        set_sel(2'd3, 1'b0, 12'd57);
        n = 100;
        do begin
            @(negedge clk);
            n++;
        end while (!hd && n < 5000);
        chk(n == 2669, "R11 mid-line select change", n, 2669);
        set_sel(2'd0, 1'b0, 12'd5);
        measure(n);
        chk(n == 686, "R9 line after mid-line change", n, 686);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule